// File: doc/BRIEF.md
# Modbus Two-Register Sensor Poller

This block is the master side of a serial sensor link. Each time it is triggered, it sends one read request for two consecutive 16-bit holding registers to a remote sensor. It then collects the nine-byte reply and checks the reply's header and CRC. When the reply is good, the block joins the two registers into a single 32-bit reading. The block connects to a byte-wide UART transmitter through a valid/ready handshake and to a UART receiver through a byte strobe. The UARTs themselves sit outside the block.

Each transaction uses the settings taken when the trigger is accepted:

- the slave address,
- the first register number,
- the word order used to build the 32-bit reading,
- whether the reading is treated as signed.

The reading is presented as 33 bits. Bit 32 extends the sign when signed mode is in use. Each transaction ends with exactly one one-cycle pulse: reading valid, header/CRC error, or timeout. A free-running bit tick from the UART baud generator gives the timeout window its unit of time.

Top module: `mb_poll_engine`

## Requirements
- R1: A request is the eight bytes, in this order: slave address, 0x03, start register high byte, start register low byte, 0x00, 0x02, then the CRC low byte and the CRC high byte. The CRC is the reflected CRC-16 with polynomial 0xA001 and initial value 0xFFFF, taken over the first six bytes. For address 0x01 and start 0x0000 the request is 01 03 00 00 00 02 C4 0B.
- R2: A request byte is transferred only on a clock edge where both `tx_valid_o` and `tx_ready_i` are high. While `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` stay unchanged.
- R3: A reply is accepted only if its byte 0 equals the polled address, its byte 1 is 0x03 and its byte 2 is 0x04. A reply that fails this check gives one `crc_err_o` pulse, no `valid_o` pulse, and leaves `reading_o` unchanged.
- R4: The CRC over all nine reply bytes, with the CRC sent low byte first, must leave a zero remainder. On a CRC mismatch the block gives one `crc_err_o` pulse, no `valid_o` pulse, and leaves `reading_o` unchanged.
- R5: Reply bytes 3 and 4 form the first register and bytes 5 and 6 form the second register, with the high byte of each register first. With `cfg_lo_first_i`=0, the first register supplies bits 31:16 of the reading.
- R6: With `cfg_lo_first_i`=1, the first register supplies bits 15:0 of the reading. The reply 01 03 04 12 5D 00 00 6E 99 gives the reading 0x0000125D.
- R7: With `cfg_signed_i`=1, `reading_o[32]` copies bit 31, so the 33-bit output equals the 32-bit value minus 2^32 when bit 31 is set. With `cfg_signed_i`=0, `reading_o[32]` is 0.
- R8: If nine reply bytes have not arrived within `cfg_timeout_i` bit ticks after the last request byte is transferred, the block gives one `timeout_o` pulse and returns to idle, ready for a new trigger.
- R9: A `poll_i` pulse that arrives while a transaction is in progress is ignored: it sends no additional request bytes.
- R10: Bytes on `rx_valid_i` that arrive while no reply is expected are ignored and do not affect the next reply.
- R11: After reset, `reading_o` is 0, `tx_valid_o` is low, and no result pulse is active.
- R12: `valid_o`, `crc_err_o` and `timeout_o` are each one cycle long, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Starts a transaction when the block is idle |
| cfg_addr_i | input | 8 | Slave address of the sensor |
| cfg_reg_i | input | 16 | Number of the first register to read |
| cfg_lo_first_i | input | 1 | 1: the first register is the low word |
| cfg_signed_i | input | 1 | 1: the reading is treated as two's complement |
| cfg_timeout_i | input | TMO_W | Length of the reply window, in bit ticks |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| tx_data_o | output | 8 | Request byte to the UART transmitter |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to send |
| tx_ready_i | input | 1 | The UART transmitter takes the byte |
| rx_data_i | input | 8 | Byte from the UART receiver |
| rx_valid_i | input | 1 | `rx_data_i` is a new byte |
| reading_o | output | 33 | Last accepted reading; bit 32 is the sign extension |
| valid_o | output | 1 | One-cycle pulse: `reading_o` was updated |
| timeout_o | output | 1 | One-cycle pulse: no complete reply arrived in time |
| crc_err_o | output | 1 | One-cycle pulse: the reply failed the header or CRC check |

## Verification
The hardest case to reach from the ports is a reply that is cut off partway through. The block must wait out the full tick window and not mistake the bytes already received for a complete reply. The bench feeds only five reply bytes while a slow bit tick runs. It then checks that no result pulse has appeared well before the window closes and that exactly one timeout pulse appears after it. A second hard case is a trigger that arrives while the block is waiting for a reply. To reach it, the bench pulses `poll_i` after the request has gone out. It then counts the transmitted bytes and checks that the late reply is still accepted.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } mbp_state_e;

    localparam logic [7:0]  FN_READ_HOLD = 8'h03;
    localparam int          REG_QTY      = 2;
    localparam int          REQ_BYTES    = 8;
    localparam int          RSP_BYTES    = 3 + 2 * REG_QTY + 2;
    localparam logic [7:0]  RSP_DATA_LEN = 8'(2 * REG_QTY);
    localparam logic [15:0] CRC_INIT     = 16'hFFFF;
    localparam logic [15:0] CRC_POLY     = 16'hA001;
endpackage

// File: rtl/mbp_crc_step.sv
module mbp_crc_step
    import mbp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [15:0]       crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [15:0]       crc_o
);
    logic [15:0] stage [0:BYTE_W];

    assign stage[0] = crc_i ^ 16'(byte_i);

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ CRC_POLY)
                                        : (stage[g] >> 1);
    end

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/mbp_req_builder.sv
module mbp_req_builder
    import mbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  addr_i,
    input  logic [15:0] reg_i,
    output logic [7:0]  tx_data_o,
    output logic        tx_valid_o,
    input  logic        tx_ready_i,
    output logic        done_o
);
    localparam int IDX_W = $clog2(REQ_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REQ_BYTES - 1);
    localparam logic [IDX_W-1:0] CRC_IDX  = IDX_W'(REQ_BYTES - 2);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [7:0]       addr;
        logic [15:0]      regn;
        logic [15:0]      crc;
    } bld_t;

    bld_t        s_d, s_q;
    logic [7:0]  cur_byte;
    logic [15:0] crc_next;

    mbp_crc_step #(.BYTE_W(8)) i_crc (
        .crc_i  (s_q.crc),
        .byte_i (cur_byte),
        .crc_o  (crc_next)
    );

    always_comb begin
        case (s_q.idx)
            3'd0:    cur_byte = s_q.addr;
            3'd1:    cur_byte = FN_READ_HOLD;
            3'd2:    cur_byte = s_q.regn[15:8];
            3'd3:    cur_byte = s_q.regn[7:0];
            3'd4:    cur_byte = 8'(REG_QTY >> 8);
            3'd5:    cur_byte = 8'(REG_QTY);
            3'd6:    cur_byte = s_q.crc[7:0];
            default: cur_byte = s_q.crc[15:8];
        endcase
    end

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        if (!s_q.active) begin
            if (start_i) begin
                s_d.active = 1'b1;
                s_d.idx    = '0;
                s_d.addr   = addr_i;
                s_d.regn   = reg_i;
                s_d.crc    = CRC_INIT;
            end
        end else if (tx_ready_i) begin
            if (s_q.idx < CRC_IDX) begin
                s_d.crc = crc_next;
            end
            if (s_q.idx == LAST_IDX) begin
                s_d.active = 1'b0;
                done_o     = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_data_o  = cur_byte;
    assign tx_valid_o = s_q.active;
endmodule

// File: rtl/mbp_rsp_parser.sv
module mbp_rsp_parser
    import mbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        en_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_data_i,
    input  logic [7:0]  addr_i,
    output logic        done_o,
    output logic        good_o,
    output logic [31:0] regs_o
);
    localparam int CNT_W = $clog2(RSP_BYTES + 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(RSP_BYTES);
    localparam logic [CNT_W-1:0] DATA_LO  = CNT_W'(3);
    localparam logic [CNT_W-1:0] DATA_HI  = CNT_W'(3 + 2 * REG_QTY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hdr_ok;
        logic [15:0]      crc;
        logic [31:0]      regs;
    } psr_t;

    psr_t        s_d, s_q;
    logic [15:0] crc_next;
    logic        take;

    mbp_crc_step #(.BYTE_W(8)) i_crc (
        .crc_i  (s_q.crc),
        .byte_i (rx_data_i),
        .crc_o  (crc_next)
    );

    assign take = en_i && rx_valid_i && (s_q.cnt < FULL);

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt    = '0;
            s_d.hdr_ok = 1'b1;
            s_d.crc    = CRC_INIT;
            s_d.regs   = '0;
        end else if (take) begin
            s_d.crc = crc_next;
            s_d.cnt = s_q.cnt + 1'b1;
            case (s_q.cnt)
                CNT_W'(0): if (rx_data_i != addr_i)       s_d.hdr_ok = 1'b0;
                CNT_W'(1): if (rx_data_i != FN_READ_HOLD) s_d.hdr_ok = 1'b0;
                CNT_W'(2): if (rx_data_i != RSP_DATA_LEN) s_d.hdr_ok = 1'b0;
                default: ;
            endcase
            if (s_q.cnt >= DATA_LO && s_q.cnt <= DATA_HI) begin
                s_d.regs = {s_q.regs[23:0], rx_data_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = en_i && (s_q.cnt == FULL);
    assign good_o = s_q.hdr_ok && (s_q.crc == 16'h0000);
    assign regs_o = s_q.regs;
endmodule

// File: rtl/mbp_word_join.sv
module mbp_word_join #(
    parameter int WORD_W = 16
) (
    input  logic [2*WORD_W-1:0] regs_i,
    input  logic                lo_first_i,
    input  logic                signed_i,
    output logic [2*WORD_W:0]   value_o
);
    logic [WORD_W-1:0]   first_w, second_w;
    logic [2*WORD_W-1:0] joined;

    assign first_w  = regs_i[2*WORD_W-1:WORD_W];
    assign second_w = regs_i[WORD_W-1:0];
    assign joined   = lo_first_i ? {second_w, first_w} : {first_w, second_w};
    assign value_o  = {signed_i & joined[2*WORD_W-1], joined};
endmodule

// File: rtl/mb_poll_engine.sv
module mb_poll_engine
    import mbp_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_i,
    input  logic [7:0]       cfg_addr_i,
    input  logic [15:0]      cfg_reg_i,
    input  logic             cfg_lo_first_i,
    input  logic             cfg_signed_i,
    input  logic [TMO_W-1:0] cfg_timeout_i,
    input  logic             bit_tick_i,
    output logic [7:0]       tx_data_o,
    output logic             tx_valid_o,
    input  logic             tx_ready_i,
    input  logic [7:0]       rx_data_i,
    input  logic             rx_valid_i,
    output logic [32:0]      reading_o,
    output logic             valid_o,
    output logic             timeout_o,
    output logic             crc_err_o
);
    typedef struct packed {
        mbp_state_e       state;
        logic [TMO_W-1:0] tmo_cnt;
        logic [7:0]       addr;
        logic             lo_first;
        logic             sgn;
        logic [32:0]      reading;
        logic             valid;
        logic             tmo;
        logic             err;
    } eng_t;

    eng_t        s_d, s_q;
    logic        bld_start, req_done;
    logic        rsp_done, rsp_good;
    logic [31:0] rsp_regs;
    logic [32:0] joined;

    assign bld_start = (s_q.state == ST_IDLE) && poll_i;

    mbp_req_builder i_bld (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (bld_start),
        .addr_i     (cfg_addr_i),
        .reg_i      (cfg_reg_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_ready_i (tx_ready_i),
        .done_o     (req_done)
    );

    mbp_rsp_parser i_psr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (req_done),
        .en_i       (s_q.state == ST_WAIT),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .addr_i     (s_q.addr),
        .done_o     (rsp_done),
        .good_o     (rsp_good),
        .regs_o     (rsp_regs)
    );

    mbp_word_join #(.WORD_W(16)) i_join (
        .regs_i     (rsp_regs),
        .lo_first_i (s_q.lo_first),
        .signed_i   (s_q.sgn),
        .value_o    (joined)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.tmo   = 1'b0;
        s_d.err   = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (poll_i) begin
                    s_d.state    = ST_SEND;
                    s_d.addr     = cfg_addr_i;
                    s_d.lo_first = cfg_lo_first_i;
                    s_d.sgn      = cfg_signed_i;
                end
            end
            ST_SEND: begin
                if (req_done) begin
                    s_d.state   = ST_WAIT;
                    s_d.tmo_cnt = '0;
                end
            end
            ST_WAIT: begin
                if (rsp_done) begin
                    s_d.state = ST_IDLE;
                    if (rsp_good) begin
                        s_d.reading = joined;
                        s_d.valid   = 1'b1;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end else if (bit_tick_i) begin
                    if ((s_q.tmo_cnt + 1'b1) >= cfg_timeout_i) begin
                        s_d.state = ST_IDLE;
                        s_d.tmo   = 1'b1;
                    end else begin
                        s_d.tmo_cnt = s_q.tmo_cnt + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign reading_o = s_q.reading;
    assign valid_o   = s_q.valid;
    assign timeout_o = s_q.tmo;
    assign crc_err_o = s_q.err;
endmodule

// File: rtl/mbp_poll_chk.sv
module mbp_poll_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  tx_data_o,
    input logic        tx_valid_o,
    input logic        tx_ready_i,
    input logic [32:0] reading_o,
    input logic        valid_o,
    input logic        timeout_o,
    input logic        crc_err_o
);
    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R12
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, timeout_o, crc_err_o}));

    // R3
    reading_only_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(reading_o));

    // R7
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reading_o[32] |-> reading_o[31]);

    // R12
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

bind mb_poll_engine mbp_poll_chk i_mbp_poll_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .reading_o  (reading_o),
    .valid_o    (valid_o),
    .timeout_o  (timeout_o),
    .crc_err_o  (crc_err_o)
);

// File: tb/test_mb_poll_engine.sv
`timescale 1ns/1ps
module test_mb_poll_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_i = 1'b0;
    logic [7:0]  cfg_addr_i = 8'h01;
    logic [15:0] cfg_reg_i = 16'h0000;
    logic        cfg_lo_first_i = 1'b0;
    logic        cfg_signed_i = 1'b0;
    logic [15:0] cfg_timeout_i = 16'd200;
    logic        bit_tick_i = 1'b0;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b1;
    logic [7:0]  rx_data_i = 8'h00;
    logic        rx_valid_i = 1'b0;
    logic [32:0] reading_o;
    logic        valid_o, timeout_o, crc_err_o;

    always #2.5 clk = ~clk;

    mb_poll_engine #(.TMO_W(16)) i_mb_poll_engine (
        .clk(clk), .rst_n(rst_n), .poll_i(poll_i),
        .cfg_addr_i(cfg_addr_i), .cfg_reg_i(cfg_reg_i),
        .cfg_lo_first_i(cfg_lo_first_i), .cfg_signed_i(cfg_signed_i),
        .cfg_timeout_i(cfg_timeout_i), .bit_tick_i(bit_tick_i),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
        .reading_o(reading_o), .valid_o(valid_o),
        .timeout_o(timeout_o), .crc_err_o(crc_err_o)
    );

    int n_chk = 0, n_bad = 0;
    int n_valid = 0, n_err = 0, n_tmo = 0;
    int tx_cnt = 0, cyc = 0;
    bit stall_en = 1'b0;
    logic [7:0] tx_buf [0:15];
    logic [7:0] rb [0:8];

    // Bench-side model of the transmitter, tick source and result monitor.
    always @(negedge clk) begin
        cyc++;
        bit_tick_i = (cyc % 4 == 0);
        tx_ready_i = stall_en ? (cyc % 3 == 0) : 1'b1;
        if (rst_n && tx_valid_o && tx_ready_i) begin
            if (tx_cnt < 16) tx_buf[tx_cnt] = tx_data_o;
            tx_cnt++;
        end
        if (rst_n) begin
            if (valid_o)   n_valid++;
            if (crc_err_o) n_err++;
            if (timeout_o) n_tmo++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_calc(input logic [7:0] b [0:8], input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {8'h00, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic start_poll(input logic [7:0] a, input logic [15:0] r,
                              input bit lo, input bit sg);
        @(negedge clk);
        cfg_addr_i = a; cfg_reg_i = r; cfg_lo_first_i = lo; cfg_signed_i = sg;
        tx_cnt = 0;
        poll_i = 1'b1;
        @(negedge clk);
        poll_i = 1'b0;
        for (int i = 0; i < 400 && tx_cnt < 8; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_data_i = rb[i]; rx_valid_i = 1'b1;
            @(negedge clk);
            rx_valid_i = 1'b0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic mk_rsp(input logic [7:0] a, input logic [7:0] f, input logic [7:0] bc,
                          input logic [31:0] data, input bit bad_crc);
        logic [15:0] c;
        rb[0] = a; rb[1] = f; rb[2] = bc;
        rb[3] = data[31:24]; rb[4] = data[23:16]; rb[5] = data[15:8]; rb[6] = data[7:0];
        c = crc_calc(rb, 7);
        rb[7] = c[7:0] ^ (bad_crc ? 8'h01 : 8'h00);
        rb[8] = c[15:8];
    endtask

    task automatic t_reset();
        chk("R11 reading after reset", 64'(reading_o), 64'h0);
        chk("R11 tx_valid after reset", 64'(tx_valid_o), 64'h0);
        chk("R11 pulses after reset", 64'({valid_o, timeout_o, crc_err_o}), 64'h0);
    endtask

    task automatic t_request();
        logic [7:0] exp_req [0:7];
        logic [15:0] c;
        stall_en = 1'b1;
        start_poll(8'h01, 16'h0000, 1'b0, 1'b0);
        chk("R2 byte count under stalls", 64'(tx_cnt), 64'd8);
        exp_req = '{8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h02, 8'hC4, 8'h0B};
        for (int i = 0; i < 8; i++) chk("R1 R2 request byte", 64'(tx_buf[i]), 64'(exp_req[i]));
        mk_rsp(8'h01, 8'h03, 8'h04, 32'h0000_0001, 1'b0);
        send_bytes(9);
        stall_en = 1'b0;
        start_poll(8'h11, 16'hABCD, 1'b0, 1'b0);
        rb[0] = 8'h11; rb[1] = 8'h03; rb[2] = 8'hAB; rb[3] = 8'hCD; rb[4] = 8'h00; rb[5] = 8'h02;
        c = crc_calc(rb, 6);
        chk("R1 address byte", 64'(tx_buf[0]), 64'h11);
        chk("R1 start high", 64'(tx_buf[2]), 64'hAB);
        chk("R1 start low", 64'(tx_buf[3]), 64'hCD);
        chk("R1 crc low then high", 64'({tx_buf[6], tx_buf[7]}), 64'({c[7:0], c[15:8]}));
        mk_rsp(8'h11, 8'h03, 8'h04, 32'h0000_0002, 1'b0);
        send_bytes(9);
    endtask

    task automatic t_lo_first();
        int v0 = n_valid;
        start_poll(8'h01, 16'h0000, 1'b1, 1'b0);
        rb = '{8'h01, 8'h03, 8'h04, 8'h12, 8'h5D, 8'h00, 8'h00, 8'h6E, 8'h99};
        send_bytes(9);
        chk("R6 R12 one valid pulse", 64'(n_valid - v0), 64'd1);
        chk("R6 low word first reading", 64'(reading_o), 64'h0_0000_125D);
    endtask

    task automatic t_hi_first_signed();
        start_poll(8'h05, 16'h0010, 1'b0, 1'b0);
        mk_rsp(8'h05, 8'h03, 8'h04, 32'h1234_5678, 1'b0);
        send_bytes(9);
        chk("R5 high word first", 64'(reading_o), 64'h0_1234_5678);
        start_poll(8'h05, 16'h0010, 1'b0, 1'b1);
        mk_rsp(8'h05, 8'h03, 8'h04, 32'hFFFF_FFFB, 1'b0);
        send_bytes(9);
        chk("R7 signed negative", 64'(reading_o), 64'h1_FFFF_FFFB);
        start_poll(8'h05, 16'h0010, 1'b0, 1'b0);
        send_bytes(9);
        chk("R7 unsigned same bits", 64'(reading_o), 64'h0_FFFF_FFFB);
        start_poll(8'h05, 16'h0010, 1'b1, 1'b1);
        mk_rsp(8'h05, 8'h03, 8'h04, 32'h8000_0001, 1'b0);
        send_bytes(9);
        chk("R7 R6 signed low first positive", 64'(reading_o), 64'h0_0001_8000);
    endtask

    task automatic t_bad_header();
        logic [32:0] keep = reading_o;
        int v0 = n_valid, e0 = n_err;
        start_poll(8'h07, 16'h0000, 1'b0, 1'b0);
        mk_rsp(8'h08, 8'h03, 8'h04, 32'h1111_1111, 1'b0);
        send_bytes(9);
        start_poll(8'h07, 16'h0000, 1'b0, 1'b0);
        mk_rsp(8'h07, 8'h04, 8'h04, 32'h2222_2222, 1'b0);
        send_bytes(9);
        start_poll(8'h07, 16'h0000, 1'b0, 1'b0);
        mk_rsp(8'h07, 8'h03, 8'h06, 32'h3333_3333, 1'b0);
        send_bytes(9);
        chk("R3 error pulses for bad header", 64'(n_err - e0), 64'd3);
        chk("R3 no valid for bad header", 64'(n_valid - v0), 64'd0);
        chk("R3 reading kept", 64'(reading_o), 64'(keep));
    endtask

    task automatic t_bad_crc();
        logic [32:0] keep = reading_o;
        int v0 = n_valid, e0 = n_err;
        start_poll(8'h09, 16'h0002, 1'b0, 1'b0);
        mk_rsp(8'h09, 8'h03, 8'h04, 32'hDEAD_BEEF, 1'b1);
        send_bytes(9);
        chk("R4 error pulse on crc mismatch", 64'(n_err - e0), 64'd1);
        chk("R4 no valid on crc mismatch", 64'(n_valid - v0), 64'd0);
        chk("R4 reading kept", 64'(reading_o), 64'(keep));
    endtask

    task automatic t_timeout();
        int t0 = n_tmo, v0 = n_valid, e0 = n_err;
        cfg_timeout_i = 16'd20;
        start_poll(8'h01, 16'h0000, 1'b0, 1'b0);
        mk_rsp(8'h01, 8'h03, 8'h04, 32'h0000_00AA, 1'b0);
        send_bytes(5);
        repeat (40) @(negedge clk);
        chk("R8 no early timeout", 64'(n_tmo - t0), 64'd0);
        repeat (40) @(negedge clk);
        chk("R8 one timeout pulse", 64'(n_tmo - t0), 64'd1);
        chk("R8 no other result", 64'((n_valid - v0) + (n_err - e0)), 64'd0);
        cfg_timeout_i = 16'd200;
        start_poll(8'h01, 16'h0000, 1'b0, 1'b0);
        chk("R8 new request after timeout", 64'(tx_cnt), 64'd8);
        send_bytes(9);
        chk("R8 valid after recovery", 64'(reading_o), 64'h0_0000_00AA);
    endtask

    task automatic t_busy();
        int v0 = n_valid;
        start_poll(8'h02, 16'h0004, 1'b0, 1'b0);
        @(negedge clk); poll_i = 1'b1; @(negedge clk); poll_i = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 poll while waiting ignored", 64'(tx_cnt), 64'd8);
        mk_rsp(8'h02, 8'h03, 8'h04, 32'h0102_0304, 1'b0);
        send_bytes(9);
        chk("R9 reply still accepted", 64'(n_valid - v0), 64'd1);
        chk("R9 reading", 64'(reading_o), 64'h0_0102_0304);
        repeat (10) @(negedge clk);
        chk("R9 no extra request", 64'(tx_cnt), 64'd8);
    endtask

    task automatic t_idle_rx();
        int e0 = n_err;
        rb = '{8'h03, 8'h03, 8'h04, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send_bytes(3);
        start_poll(8'h03, 16'h0000, 1'b0, 1'b0);
        mk_rsp(8'h03, 8'h03, 8'h04, 32'hCAFE_0042, 1'b0);
        send_bytes(9);
        chk("R10 stray bytes ignored", 64'(reading_o), 64'h0_CAFE_0042);
        chk("R10 no error from stray bytes", 64'(n_err - e0), 64'd0);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_request();
        t_lo_first();
        t_hi_first_signed();
        t_bad_header();
        t_bad_crc();
        t_timeout();
        t_busy();
        t_idle_rx();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule